// File: doc/BRIEF.md
# Converter Mode and Calibration Sequencer

This block is the digital control core of a sigma-delta converter. It keeps an 8-bit setup register that a host loads and reads over a plain parallel register port. From the two mode bits of that register it runs normal conversion, a one-step self-calibration, a zero-scale system calibration or a full-scale system calibration. It also drives the data-ready flag and holds the digital filter in reset while the sync bit is set.

The modulator and the filter are modelled abstractly. A one-cycle update tick marks each new filter output, and a sample bus carries that output. In normal mode each tick after settling loads the data register. During calibration the last tick of each step is captured into the offset or the gain coefficient register. The coefficient arithmetic, the serial host link and the analog front end are outside the block.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset the setup register reads 0x01, data-ready is high, the filter reset output is high, and the data, offset and gain registers are zero.
- R2: A write stores reg_wdata into the setup register, which reads back on setup_q the next cycle. The field layout is bit 7..6 mode, bits 5..3 gain code, bit 2 unipolar (1) / bipolar (0), bit 1 input buffer enable, bit 0 filter sync. filt_rst, unipolar and buf_en follow bits 0, 2 and 1.
- R3: gain_mult is one-hot with bit k set for gain code k, so the gain is 2^code, from 1 at code 0 to 128 at code 7.
- R4: While the sync bit is 1, update ticks are ignored. The data register, data-ready and the coefficient registers do not change, and no calibration step runs.
- R5: After a write that clears the sync bit with mode 00, the first two ticks load nothing. The third tick loads its sample into the data register and drives data-ready low.
- R6: In normal mode every tick loads the sample and drives data-ready low. A data_rd pulse drives data-ready high. When a tick and a read fall in the same cycle, the load wins and data-ready ends low.
- R7: A write that clears the sync bit and selects mode 01, 10 or 11 starts a calibration and drives data-ready high in the next cycle. Data-ready stays high until the calibration has finished and a word has been loaded.
- R8: Mode 01 runs a zero step of CAL_TICKS ticks with in_short high, then a full step of CAL_TICKS ticks with ref_int high. The sample of the last tick of each step goes to offset_q and gain_q respectively. At the end the mode bits read back as 00.
- R9: Mode 10 runs only a zero step with in_short low. The last sample goes to offset_q, gain_q is unchanged, and the mode bits then clear to 00.
- R10: Mode 11 runs only a full step with ref_int low. The last sample goes to gain_q, offset_q is unchanged, and the mode bits then clear to 00.
- R11: After a calibration ends, the next tick loads the data register and drives data-ready low, with no settling delay.
- R12: A write during a calibration aborts it without capture and restarts sequencing from the written mode. When the write coincides with the final tick of a step, the write wins: setup_q holds the written value and nothing is captured.
- R13: Setting the sync bit while data-ready is low leaves data-ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Setup register write strobe |
| reg_wdata | input | 8 | Setup register write value |
| setup_q | output | 8 | Setup register read value |
| data_rd | input | 1 | Data register read strobe |
| data_q | output | DATA_W | Data register |
| drdy | output | 1 | Data-ready flag, low when a fresh word is waiting |
| upd_tick | input | 1 | One-cycle marker of a filter output |
| sample | input | DATA_W | Filter output value |
| filt_rst | output | 1 | Holds filter and modulator in reset |
| in_short | output | 1 | Inputs internally shorted (self zero step) |
| ref_int | output | 1 | Internal reference over gain applied (self full step) |
| cal_busy | output | 1 | A calibration step is running |
| gain_mult | output | 8 | One-hot gain selection |
| unipolar | output | 1 | Unipolar coding selected |
| buf_en | output | 1 | Input buffer enabled |
| offset_q | output | DATA_W | Offset coefficient register |
| gain_q | output | DATA_W | Gain coefficient register |

## Verification
Two pairs of events can land in the same cycle. The first is an update tick that loads a word together with a host read that would raise data-ready. The second is a host write together with the final tick of a calibration step, which would otherwise clear the mode bits and capture a coefficient. The bench drives each pair in the same clock cycle. It then judges the outcome one cycle later at the ports: data-ready must be low with the new word in the data register, and the written setup value must survive with the coefficients unchanged. A scoreboard queue holds every data word expected to appear, so a missing, early or extra load shows up as a mismatch.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   localparam int SETUP_W = 8;
   localparam int GCODE_W = 3;
   localparam int GAIN_N  = 1 << GCODE_W;

   localparam int POS_MODE_HI = 7;
   localparam int POS_MODE_LO = 6;
   localparam int POS_GAIN_HI = 5;
   localparam int POS_GAIN_LO = 3;
   localparam int POS_UNI     = 2;
   localparam int POS_BUF     = 1;
   localparam int POS_SYNC    = 0;

   localparam logic [SETUP_W-1:0] SETUP_RST = 8'h01;

   localparam logic [1:0] MODE_NORM = 2'b00;
   localparam logic [1:0] MODE_SELF = 2'b01;
   localparam logic [1:0] MODE_SZS  = 2'b10;
   localparam logic [1:0] MODE_SFS  = 2'b11;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_SETTLE,
      ST_NORM,
      ST_CALZ,
      ST_CALF
   } seq_state_t;
endpackage

// File: rtl/adcseq_setup_reg.sv
module adcseq_setup_reg
   import adcseq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [SETUP_W-1:0] wdata,
   input  logic               cal_done,
   output logic [SETUP_W-1:0] setup,
   output logic [1:0]         mode,
   output logic               fsync,
   output logic               unipolar,
   output logic               buf_en,
   output logic [GAIN_N-1:0]  gain_mult
);
   logic [GCODE_W-1:0] gcode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup <= SETUP_RST;
      end else if (wr) begin
         setup <= wdata;
      end else if (cal_done) begin
         setup[POS_MODE_HI:POS_MODE_LO] <= MODE_NORM;
      end
   end

   assign mode     = setup[POS_MODE_HI:POS_MODE_LO];
   assign gcode    = setup[POS_GAIN_HI:POS_GAIN_LO];
   assign fsync    = setup[POS_SYNC];
   assign unipolar = setup[POS_UNI];
   assign buf_en   = setup[POS_BUF];

   for (genvar k = 0; k < GAIN_N; k++) begin : g_gain
      assign gain_mult[k] = (gcode == GCODE_W'(k));
   end
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
   import adcseq_pkg::*;
#(
   parameter int CAL_TICKS    = 4,
   parameter int SETTLE_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wr_mode,
   input  logic       wr_sync,
   input  logic [1:0] mode,
   input  logic       tick,
   output logic       load_data,
   output logic       cap_off,
   output logic       cap_gain,
   output logic       cal_start,
   output logic       cal_done,
   output logic       in_short,
   output logic       ref_int,
   output logic       cal_busy
);
   localparam int MAX_T = (CAL_TICKS > SETTLE_TICKS) ? CAL_TICKS : SETTLE_TICKS;
   localparam int CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_TICKS - 1);
   localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_TICKS - 1);

   seq_state_t state, entry;
   logic [CNT_W-1:0] cnt;
   logic cal_last, set_last, self_mode, live_tick;

   always_comb begin
      if (wr_sync)                   entry = ST_HOLD;
      else if (wr_mode == MODE_NORM) entry = ST_SETTLE;
      else if (wr_mode == MODE_SFS)  entry = ST_CALF;
      else                           entry = ST_CALZ;
   end

   assign self_mode = (mode == MODE_SELF);
   assign cal_last  = (cnt == CAL_LAST);
   assign set_last  = (cnt == SET_LAST);
   assign live_tick = tick && !wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HOLD;
         cnt   <= '0;
      end else if (wr) begin
         state <= entry;
         cnt   <= '0;
      end else if (tick) begin
         unique case (state)
            ST_SETTLE: begin
               if (set_last) begin
                  state <= ST_NORM;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CALZ: begin
               if (cal_last) begin
                  state <= self_mode ? ST_CALF : ST_NORM;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CALF: begin
               if (cal_last) begin
                  state <= ST_NORM;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign load_data = live_tick && ((state == ST_NORM) || (state == ST_SETTLE && set_last));
   assign cap_off   = live_tick && (state == ST_CALZ) && cal_last;
   assign cap_gain  = live_tick && (state == ST_CALF) && cal_last;
   assign cal_done  = cap_gain || (cap_off && !self_mode);
   assign cal_start = wr && (entry == ST_CALZ || entry == ST_CALF);
   assign in_short  = (state == ST_CALZ) && self_mode;
   assign ref_int   = (state == ST_CALF) && self_mode;
   assign cal_busy  = (state == ST_CALZ) || (state == ST_CALF);
endmodule

// File: rtl/adcseq_store.sv
module adcseq_store #(
   parameter int DATA_W    = 16,
   parameter bit LOAD_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] sample,
   input  logic              load_data,
   input  logic              cap_off,
   input  logic              cap_gain,
   input  logic              cal_start,
   input  logic              data_rd,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] offset_q,
   output logic [DATA_W-1:0] gain_q,
   output logic              drdy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         offset_q <= '0;
         gain_q   <= '0;
      end else begin
         if (load_data) data_q   <= sample;
         if (cap_off)   offset_q <= sample;
         if (cap_gain)  gain_q   <= sample;
      end
   end

   if (LOAD_WINS) begin : g_load_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    drdy <= 1'b1;
         else if (load_data)            drdy <= 1'b0;
         else if (cal_start || data_rd) drdy <= 1'b1;
      end
   end else begin : g_read_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    drdy <= 1'b1;
         else if (cal_start || data_rd) drdy <= 1'b1;
         else if (load_data)            drdy <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
   import adcseq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CAL_TICKS    = 4,
   parameter int SETTLE_TICKS = 3,
   parameter bit LOAD_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        setup_q,
   input  logic              data_rd,
   output logic [DATA_W-1:0] data_q,
   output logic              drdy,
   input  logic              upd_tick,
   input  logic [DATA_W-1:0] sample,
   output logic              filt_rst,
   output logic              in_short,
   output logic              ref_int,
   output logic              cal_busy,
   output logic [7:0]        gain_mult,
   output logic              unipolar,
   output logic              buf_en,
   output logic [DATA_W-1:0] offset_q,
   output logic [DATA_W-1:0] gain_q
);
   if (DATA_W < 8)        begin : g_bad_w  $error("DATA_W must be at least 8"); end
   if (CAL_TICKS < 1)     begin : g_bad_c  $error("CAL_TICKS must be at least 1"); end
   if (SETTLE_TICKS < 1)  begin : g_bad_s  $error("SETTLE_TICKS must be at least 1"); end
   if (GAIN_N != 8)       begin : g_bad_g  $error("gain decode must be 8 wide"); end

   logic [1:0] mode;
   logic load_data, cap_off, cap_gain, cal_start, cal_done;

   adcseq_setup_reg u_setup (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .cal_done  (cal_done),
      .setup     (setup_q),
      .mode      (mode),
      .fsync     (filt_rst),
      .unipolar  (unipolar),
      .buf_en    (buf_en),
      .gain_mult (gain_mult)
   );

   adcseq_fsm #(
      .CAL_TICKS    (CAL_TICKS),
      .SETTLE_TICKS (SETTLE_TICKS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .wr_mode   (reg_wdata[POS_MODE_HI:POS_MODE_LO]),
      .wr_sync   (reg_wdata[POS_SYNC]),
      .mode      (mode),
      .tick      (upd_tick),
      .load_data (load_data),
      .cap_off   (cap_off),
      .cap_gain  (cap_gain),
      .cal_start (cal_start),
      .cal_done  (cal_done),
      .in_short  (in_short),
      .ref_int   (ref_int),
      .cal_busy  (cal_busy)
   );

   adcseq_store #(
      .DATA_W    (DATA_W),
      .LOAD_WINS (LOAD_WINS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .load_data (load_data),
      .cap_off   (cap_off),
      .cap_gain  (cap_gain),
      .cal_start (cal_start),
      .data_rd   (data_rd),
      .data_q    (data_q),
      .offset_q  (offset_q),
      .gain_q    (gain_q),
      .drdy      (drdy)
   );
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        setup_q,
   input logic              upd_tick,
   input logic [DATA_W-1:0] data_q,
   input logic [DATA_W-1:0] offset_q,
   input logic              drdy,
   input logic              filt_rst,
   input logic              in_short,
   input logic              ref_int,
   input logic [7:0]        gain_mult
);
   assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (setup_q == $past(reg_wdata)));

   assert_low_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (setup_q[5:0] == $past(setup_q[5:0])));

   assert_gain_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gain_mult) == 1);

   assert_sync_freezes_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_rst && !reg_wr) |=> ($stable(data_q) && $stable(offset_q)));

   assert_sync_no_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      filt_rst |-> !(in_short || ref_int));

   assert_ready_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy) |-> $past(upd_tick));

   assert_cal_raises_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[0] && (reg_wdata[7:6] != 2'b00)) |=> drdy);

   assert_one_cal_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({in_short, ref_int}));
endmodule

bind adc_cal_sequencer adcseq_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .setup_q   (setup_q),
   .upd_tick  (upd_tick),
   .data_q    (data_q),
   .offset_q  (offset_q),
   .drdy      (drdy),
   .filt_rst  (filt_rst),
   .in_short  (in_short),
   .ref_int   (ref_int),
   .gain_mult (gain_mult)
);

// File: tb/adc_cal_sequencer_test.sv
`timescale 1ns/1ps
module adc_cal_sequencer_test;
   localparam int DW = 16;
   localparam int CT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    setup_q;
   logic          data_rd = 1'b0;
   logic [DW-1:0] data_q;
   logic          drdy;
   logic          upd_tick = 1'b0;
   logic [DW-1:0] sample = '0;
   logic          filt_rst, in_short, ref_int, cal_busy, unipolar, buf_en;
   logic [7:0]    gain_mult;
   logic [DW-1:0] offset_q, gain_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] expq[$];
   logic [DW-1:0] prev_data = '0;

   always #5 clk = ~clk;

   adc_cal_sequencer #(.DATA_W(DW), .CAL_TICKS(CT), .SETTLE_TICKS(3)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .setup_q(setup_q), .data_rd(data_rd), .data_q(data_q), .drdy(drdy),
      .upd_tick(upd_tick), .sample(sample), .filt_rst(filt_rst),
      .in_short(in_short), .ref_int(ref_int), .cal_busy(cal_busy),
      .gain_mult(gain_mult), .unipolar(unipolar), .buf_en(buf_en),
      .offset_q(offset_q), .gain_q(gain_q)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every new data word must match the queue head
   always @(negedge clk) begin
      if (rst_n && data_q !== prev_data) begin
         if (expq.size() == 0) begin
            check(1'b0, "R6", "unexpected data load", longint'(data_q), 0);
         end else begin
            logic [DW-1:0] e;
            e = expq.pop_front();
            check(data_q === e, "R5", "scoreboard data word", longint'(data_q), longint'(e));
         end
         prev_data = data_q;
      end
   end

   // each task starts just after a falling edge and ends one cycle later
   task automatic op(input bit wr, input logic [7:0] wv, input bit tk,
                     input logic [DW-1:0] sv, input bit rd, input bit push);
      if (push) expq.push_back(sv);
      reg_wr = wr; reg_wdata = wv; upd_tick = tk; sample = sv; data_rd = rd;
      @(negedge clk);
      reg_wr = 1'b0; upd_tick = 1'b0; data_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] v);
      op(1'b1, v, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic tk(input logic [DW-1:0] v, input bit push);
      op(1'b0, 8'h00, 1'b1, v, 1'b0, push);
   endtask

   initial begin
      #(20000 * 10);
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(setup_q == 8'h01, "R1", "setup reset", setup_q, 8'h01);
      check(drdy == 1'b1 && filt_rst == 1'b1, "R1", "drdy/filt_rst", {drdy, filt_rst}, 2'b11);
      check(data_q == 0 && offset_q == 0 && gain_q == 0, "R1", "regs zero", data_q, 0);

      // R4 ticks ignored under sync
      tk(16'h0A0A, 1'b0);
      tk(16'h0B0B, 1'b0);
      check(data_q == 0 && drdy == 1'b1, "R4", "ticks under sync", data_q, 0);

      // R2 / R3 write and field outputs
      wr(8'h00);
      check(setup_q == 8'h00 && filt_rst == 1'b0, "R2", "write 00", setup_q, 8'h00);
      check(gain_mult == 8'h01, "R3", "gain code 0", gain_mult, 8'h01);

      // R5 settling
      tk(16'h1111, 1'b0);
      tk(16'h1112, 1'b0);
      check(drdy == 1'b1 && data_q == 0, "R5", "no word before third tick", data_q, 0);
      tk(16'h1113, 1'b1);
      check(drdy == 1'b0, "R5", "drdy low after settle", drdy, 0);

      // R6 normal loads, read, and tick+read collision
      tk(16'h1114, 1'b1);
      op(1'b0, 8'h00, 1'b0, '0, 1'b1, 1'b0);
      check(drdy == 1'b1, "R6", "read raises drdy", drdy, 1);
      op(1'b0, 8'h00, 1'b1, 16'h1115, 1'b1, 1'b1);
      check(drdy == 1'b0 && data_q == 16'h1115, "R6", "load beats read", drdy, 0);

      // R13 sync raised while drdy low
      wr(8'h01);
      check(drdy == 1'b0 && filt_rst == 1'b1, "R13", "drdy stays low", drdy, 0);
      tk(16'h2222, 1'b0);
      check(data_q == 16'h1115 && drdy == 1'b0, "R4", "tick ignored under sync", data_q, 16'h1115);

      // R2 / R3 fields
      wr(8'h29);
      check(gain_mult == 8'h20, "R3", "gain code 5", gain_mult, 8'h20);
      wr(8'h1F);
      check(gain_mult == 8'h08 && unipolar && buf_en, "R2", "uni/buf/gain8",
            {gain_mult, unipolar, buf_en}, {8'h08, 2'b11});

      // R8 self calibration
      wr(8'h40);
      check(drdy == 1'b1 && in_short && cal_busy, "R7", "cal start", {drdy, in_short}, 2'b11);
      for (int i = 1; i <= CT; i++) tk(DW'(16'hA000 + i), 1'b0);
      check(offset_q == 16'hA004, "R8", "self offset", offset_q, 16'hA004);
      check(ref_int && !in_short && drdy, "R8", "full step source", {ref_int, in_short}, 2'b10);
      for (int i = 1; i <= CT; i++) tk(DW'(16'hB000 + i), 1'b0);
      check(gain_q == 16'hB004 && setup_q == 8'h00, "R8", "self gain/mode clear", gain_q, 16'hB004);
      check(drdy == 1'b1 && !cal_busy, "R7", "drdy high at cal end", drdy, 1);
      tk(16'hC001, 1'b1);
      check(drdy == 1'b0, "R11", "first word after cal", drdy, 0);

      // R9 system zero
      wr(8'h80);
      check(!in_short && cal_busy && drdy, "R9", "sys zero source", in_short, 0);
      for (int i = 1; i <= CT; i++) tk(DW'(16'hD000 + i), 1'b0);
      check(offset_q == 16'hD004 && gain_q == 16'hB004, "R9", "sys zero capture", offset_q, 16'hD004);
      check(setup_q == 8'h00, "R9", "mode cleared", setup_q, 8'h00);
      tk(16'hC002, 1'b1);

      // R10 system full
      wr(8'hC0);
      check(!ref_int && cal_busy, "R10", "sys full source", ref_int, 0);
      for (int i = 1; i <= CT; i++) tk(DW'(16'hE000 + i), 1'b0);
      check(gain_q == 16'hE004 && offset_q == 16'hD004, "R10", "sys full capture", gain_q, 16'hE004);
      check(setup_q == 8'h00, "R10", "mode cleared", setup_q, 8'h00);
      tk(16'hC003, 1'b1);
      check(drdy == 1'b0, "R11", "word after sys cal", drdy, 0);

      // R12 abort and write/final-tick collision
      wr(8'h40);
      tk(16'hF001, 1'b0);
      tk(16'hF002, 1'b0);
      wr(8'h80);
      check(offset_q == 16'hD004 && setup_q == 8'h80, "R12", "abort no capture", offset_q, 16'hD004);
      for (int i = 1; i < CT; i++) tk(DW'(16'hF010 + i), 1'b0);
      op(1'b1, 8'h80, 1'b1, 16'hF014, 1'b0, 1'b0);
      check(setup_q == 8'h80 && offset_q == 16'hD004, "R12", "write beats final tick",
            setup_q, 8'h80);
      for (int i = 1; i <= CT; i++) tk(DW'(16'hF020 + i), 1'b0);
      check(offset_q == 16'hF024 && setup_q == 8'h00, "R12", "restarted cal", offset_q, 16'hF024);
      tk(16'hC004, 1'b1);
      check(data_q == 16'hC004, "R11", "word after restart", data_q, 16'hC004);

      @(negedge clk);
      check(expq.size() == 0, "R6", "scoreboard drained", expq.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule